// File: doc/BRIEF.md
# Ownership Trace Message Generator

This block watches the register in which operating-system software records the identity of the running task or process. Each write to that register is one task switch. On each write the block keeps a copy of the new 32-bit value. It then sends a fixed-length ownership trace message over a narrow 4-bit trace data bus. A 2-bit framing output runs beside the bus and marks where each message starts and ends. A debug tool on the far side can then rebuild the task flow of the running software without tracing single instructions.

The message is 42 bits long and holds three fields:

| Field | Bits | Content |
|---|---|---|
| Message type code | [5:0] | constant `000010` |
| Source identifier | [9:6] | static 4-bit input |
| Captured task identifier | [41:10] | value kept at the write |

The message is sent in eleven 4-bit beats, least significant nibble first. The final beat is padded with zeros.

Only one message is on the wire at a time. A write that arrives while a message is being sent is held in a single pending slot. It goes out right after the current message ends. If a later write arrives before then, it replaces the pending value.

Top module: `own_trace_gen`

## Requirements
- R1: A message is started only because of a strobed write of the task identifier. Changing `pid_value_i` or `src_id_i` without the strobe starts no message.
- R2: The transmitted identifier is the value on `pid_value_i` in the cycle the strobe was high. Later changes to that input do not alter it.
- R3: Every message is exactly 11 beats of 4 bits (42 payload bits). Bits [43:42] of the last beat are zero. `mdo_o` is zero whenever the port is idle.
- R4: Message bits [5:0] carry the type code 6'b000010. With 4-bit beats, the first beat of every message is therefore 4'b0010.
- R5: Message bits [9:6] carry `src_id_i`, and bits [41:10] carry the captured identifier.
- R6: Beat k of a message carries message bits [4k+3:4k], so the least significant nibble comes first.
- R7: `frame_o` encodes 2'b11 idle, 2'b01 first beat, 2'b00 middle beat and 2'b10 last beat. A first beat follows only an idle or last beat. A last beat is followed only by idle or another first beat.
- R8: A write that arrives while a message is being sent is held. Its message begins in the cycle right after the current last beat. Of several such writes, only the newest is sent.
- R9: After reset the port is idle (`frame_o` = 2'b11, `mdo_o` = 0). It stays idle until the first write.
- R10: A new message starts two clock edges after the write strobe is sampled when the port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pid_value_i | input | 32 | Task/process identifier being written |
| pid_wr_i | input | 1 | Write strobe for the identifier, one cycle per write |
| src_id_i | input | 4 | Static source identifier placed in each message |
| mdo_o | output | 4 | Trace message data beat |
| frame_o | output | 2 | Beat framing: 11 idle, 01 first, 00 middle, 10 last |

## Verification
The assertions check the framing rules on every cycle:
- legal first-beat and last-beat neighbours;
- exactly eleven beats between the markers;
- zero data while idle;
- the type code in the first beat;
- no message leaving idle without a write two edges earlier.

Only the bench scenarios can show that the captured identifier and source land in the right bit positions. The same holds for the value being frozen at the write. Showing that only the newest of several pending writes is sent, and that the queued message follows with no gap, also needs the bench, because the checker cannot know which write values should appear.

// File: rtl/ot_pkg.sv
package ot_pkg;

   typedef enum logic [1:0] {
      FRM_MID   = 2'b00,
      FRM_START = 2'b01,
      FRM_END   = 2'b10,
      FRM_IDLE  = 2'b11
   } frame_e;

   function automatic int unsigned beats_for(input int unsigned bits, input int unsigned beat_w);
      return (bits + beat_w - 1) / beat_w;
   endfunction

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ot_capture.sv
module ot_capture #(
   parameter int unsigned PID_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [PID_W-1:0] val_i,
   input  logic             take_i,
   output logic             vld_o,
   output logic [PID_W-1:0] held_o
);

   logic             vld_q;
   logic [PID_W-1:0] held_q;

   // A fresh write always wins over a concurrent take: the taken copy is
   // the older value, and the new one stays pending.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         held_q <= '0;
      end else if (wr_i) begin
         vld_q  <= 1'b1;
         held_q <= val_i;
      end else if (take_i) begin
         vld_q  <= 1'b0;
      end
   end

   assign vld_o  = vld_q;
   assign held_o = held_q;

endmodule

// File: rtl/ot_packer.sv
module ot_packer #(
   parameter int unsigned PID_W  = 32,
   parameter int unsigned SRC_W  = 4,
   parameter int unsigned TC_W   = 6,
   parameter logic [TC_W-1:0] TC_VAL = 6'b000010,
   parameter int unsigned PAD_W  = 44
) (
   input  logic [PID_W-1:0] pid_i,
   input  logic [SRC_W-1:0] src_i,
   output logic [PAD_W-1:0] msg_o
);

   localparam int unsigned MSG_W  = TC_W + SRC_W + PID_W;
   localparam int unsigned FILL_W = PAD_W - MSG_W;

   logic [MSG_W-1:0] body;

   // Type code in the low bits, then source, then identifier.
   assign body = {pid_i, src_i, TC_VAL};

   generate
      if (FILL_W == 0) begin : g_exact
         assign msg_o = body;
      end else begin : g_padded
         assign msg_o = {{FILL_W{1'b0}}, body};
      end
   endgenerate

endmodule

// File: rtl/ot_serializer.sv
module ot_serializer
   import ot_pkg::*;
#(
   parameter int unsigned BEAT_W = 4,
   parameter int unsigned BEATS  = 11,
   parameter int unsigned PAD_W  = BEAT_W * BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  logic [PAD_W-1:0]  msg_i,
   output logic              take_o,
   output logic [BEAT_W-1:0] data_o,
   output frame_e            frame_o
);

   localparam int unsigned CNT_W = cnt_width(BEATS);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BEATS - 1);

   logic             busy_q;
   logic [CNT_W-1:0] cnt_q;
   logic [PAD_W-1:0] shreg_q;
   logic             last;

   assign last   = busy_q && (cnt_q == LAST_IDX);
   assign take_o = vld_i && (!busy_q || last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         cnt_q   <= '0;
         shreg_q <= '0;
      end else if (take_o) begin
         busy_q  <= 1'b1;
         cnt_q   <= '0;
         shreg_q <= msg_i;
      end else if (busy_q) begin
         if (last) begin
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            shreg_q <= '0;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            shreg_q <= shreg_q >> BEAT_W;
         end
      end
   end

   always_comb begin
      data_o = busy_q ? shreg_q[BEAT_W-1:0] : '0;
      if (!busy_q)             frame_o = FRM_IDLE;
      else if (cnt_q == '0)    frame_o = FRM_START;
      else if (last)           frame_o = FRM_END;
      else                     frame_o = FRM_MID;
   end

endmodule

// File: rtl/own_trace_gen.sv
module own_trace_gen
   import ot_pkg::*;
#(
   parameter int unsigned PID_W  = 32,
   parameter int unsigned SRC_W  = 4,
   parameter int unsigned TC_W   = 6,
   parameter logic [TC_W-1:0] TC_VAL = 6'b000010,
   parameter int unsigned BEAT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PID_W-1:0]  pid_value_i,
   input  logic              pid_wr_i,
   input  logic [SRC_W-1:0]  src_id_i,
   output logic [BEAT_W-1:0] mdo_o,
   output logic [1:0]        frame_o
);

   localparam int unsigned MSG_W = TC_W + SRC_W + PID_W;
   localparam int unsigned BEATS = beats_for(MSG_W, BEAT_W);
   localparam int unsigned PAD_W = BEATS * BEAT_W;

   generate
      if (BEAT_W < 1) begin : g_bad_beat
         $error("own_trace_gen: BEAT_W must be at least 1");
      end
      if (BEATS < 2) begin : g_bad_len
         $error("own_trace_gen: a message needs at least two beats for framing");
      end
      if (TC_W < 1 || PID_W < 1 || SRC_W < 1) begin : g_bad_field
         $error("own_trace_gen: every field must be at least one bit wide");
      end
   endgenerate

   logic             pend_vld;
   logic [PID_W-1:0] pend_pid;
   logic             take;
   logic [PAD_W-1:0] msg;
   frame_e           frame;

   ot_capture #(.PID_W(PID_W)) i_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (pid_wr_i),
      .val_i  (pid_value_i),
      .take_i (take),
      .vld_o  (pend_vld),
      .held_o (pend_pid)
   );

   ot_packer #(
      .PID_W  (PID_W),
      .SRC_W  (SRC_W),
      .TC_W   (TC_W),
      .TC_VAL (TC_VAL),
      .PAD_W  (PAD_W)
   ) i_packer (
      .pid_i (pend_pid),
      .src_i (src_id_i),
      .msg_o (msg)
   );

   ot_serializer #(
      .BEAT_W (BEAT_W),
      .BEATS  (BEATS),
      .PAD_W  (PAD_W)
   ) i_serializer (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (pend_vld),
      .msg_i   (msg),
      .take_o  (take),
      .data_o  (mdo_o),
      .frame_o (frame)
   );

   assign frame_o = frame;

endmodule

// File: rtl/ot_checker.sv
module ot_checker #(
   parameter int unsigned PID_W  = 32,
   parameter int unsigned SRC_W  = 4,
   parameter int unsigned TC_W   = 6,
   parameter logic [TC_W-1:0] TC_VAL = 6'b000010,
   parameter int unsigned BEAT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pid_wr,
   input logic [BEAT_W-1:0] mdo,
   input logic [1:0]        frame
);

   localparam int unsigned MSG_W = TC_W + SRC_W + PID_W;
   localparam int unsigned BEATS = (MSG_W + BEAT_W - 1) / BEAT_W;
   localparam logic [1:0] F_MID = 2'b00, F_START = 2'b01, F_END = 2'b10, F_IDLE = 2'b11;

   int unsigned beat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                beat_cnt <= 0;
      else if (frame == F_START) beat_cnt <= 1;
      else if (frame == F_MID)   beat_cnt <= beat_cnt + 1;
      else                       beat_cnt <= 0;
   end

   // R7
   start_follows_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_START) |-> ($past(frame) == F_IDLE || $past(frame) == F_END));

   // R7
   end_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_END) |=> (frame == F_IDLE || frame == F_START));

   // R3
   msg_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_END) |-> (beat_cnt == BEATS - 1));

   // R3
   mid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_MID) |-> (beat_cnt >= 1 && beat_cnt <= BEATS - 2));

   // R3
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_IDLE) |-> (mdo == '0));

   // R1 R10
   start_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame == F_START && $past(frame) == F_IDLE) |-> $past(pid_wr, 2));

   generate
      if (TC_W >= BEAT_W) begin : g_tc_beat
         // R4
         first_beat_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (frame == F_START) |-> (mdo == TC_VAL[BEAT_W-1:0]));
      end
   endgenerate

endmodule

bind own_trace_gen ot_checker #(
   .PID_W  (PID_W),
   .SRC_W  (SRC_W),
   .TC_W   (TC_W),
   .TC_VAL (TC_VAL),
   .BEAT_W (BEAT_W)
) i_ot_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .pid_wr (pid_wr_i),
   .mdo    (mdo_o),
   .frame  (frame_o)
);

// File: tb/test_own_trace_gen.sv
module test_own_trace_gen;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 11;
   localparam int NV = 6;
   // {src, pid}
   localparam logic [35:0] VEC [0:NV-1] = '{
      {4'h0, 32'h0000_0000},
      {4'hF, 32'hFFFF_FFFF},
      {4'h5, 32'h1234_5678},
      {4'hA, 32'hDEAD_BEEF},
      {4'h3, 32'h8000_0001},
      {4'hC, 32'h0F0F_A5A5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pid_value = '0;
   logic        pid_wr = 1'b0;
   logic [3:0]  src_id = '0;
   logic [3:0]  mdo;
   logic [1:0]  frame;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   logic [43:0] rx_msg   [0:63];
   int          rx_len   [0:63];
   int          rx_start [0:63];
   int          rx_end   [0:63];
   int          rx_cnt = 0;
   int          frame_err = 0;
   int          idle_err = 0;
   logic [43:0] acc;
   int          nb = 0;
   bit          in_msg = 0;
   int          st_cyc = 0;

   own_trace_gen i_own_trace_gen (
      .clk         (clk),
      .rst_n       (rst_n),
      .pid_value_i (pid_value),
      .pid_wr_i    (pid_wr),
      .src_id_i    (src_id),
      .mdo_o       (mdo),
      .frame_o     (frame)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   function automatic logic [43:0] exp_msg(input logic [31:0] pid, input logic [3:0] src);
      return {2'b00, pid, src, 6'b000010};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // receiver: assemble beats at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         case (frame)
            2'b01: begin
               if (in_msg) frame_err++;
               in_msg = 1; acc = '0; nb = 0; st_cyc = cyc;
               acc[3:0] = mdo; nb = 1;
            end
            2'b00: begin
               if (!in_msg) frame_err++;
               else begin
                  if (nb < NB) acc[nb*4 +: 4] = mdo;
                  nb++;
               end
            end
            2'b10: begin
               if (!in_msg) frame_err++;
               else begin
                  if (nb < NB) acc[nb*4 +: 4] = mdo;
                  nb++;
                  if (rx_cnt < 64) begin
                     rx_msg[rx_cnt] = acc; rx_len[rx_cnt] = nb;
                     rx_start[rx_cnt] = st_cyc; rx_end[rx_cnt] = cyc;
                     rx_cnt++;
                  end
                  in_msg = 0;
               end
            end
            default: begin
               if (in_msg) frame_err++;
               if (mdo != 4'h0) idle_err++;
            end
         endcase
      end
   end

   task automatic write_pid(input logic [31:0] v);
      @(negedge clk);
      pid_value = v; pid_wr = 1'b1;
      @(negedge clk);
      pid_wr = 1'b0;
   endtask

   task automatic idle_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_rx(input int n, input string req);
      int t;
      t = 0;
      while (rx_cnt < n && t < 200) begin
         @(negedge clk); #1; t++;
      end
      chk(rx_cnt >= n, req, 64'(rx_cnt), 64'(n));
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base;
      int t0;
      idle_cycles(3);
      #1;
      chk(frame == 2'b11, "R9 idle frame in reset", 64'(frame), 64'd3);
      chk(mdo == 4'h0, "R9 idle data in reset", 64'(mdo), 64'd0);
      @(negedge clk); rst_n = 1'b1;
      idle_cycles(20); #1;
      chk(frame == 2'b11, "R9 idle after reset", 64'(frame), 64'd3);
      chk(rx_cnt == 0, "R9 no message before first write", 64'(rx_cnt), 64'd0);

      // R1: inputs move without strobe
      pid_value = 32'hCAFE_F00D; src_id = 4'h9;
      idle_cycles(5);
      pid_value = 32'h1111_2222; src_id = 4'h6;
      idle_cycles(20); #1;
      chk(rx_cnt == 0, "R1 no message without strobe", 64'(rx_cnt), 64'd0);

      // R10 latency from idle
      @(negedge clk);
      pid_value = 32'h0000_00AB; pid_wr = 1'b1; t0 = cyc;
      @(negedge clk); pid_wr = 1'b0;
      wait_rx(1, "R10 message arrives");
      chk(rx_start[0] == t0 + 2, "R10 start two edges after write", 64'(rx_start[0]), 64'(t0 + 2));
      chk(rx_msg[0] == exp_msg(32'h0000_00AB, 4'h6), "R5 fields of first message",
          rx_msg[0], exp_msg(32'h0000_00AB, 4'h6));

      // table of vectors; input scrambled after the strobe (R2)
      for (int k = 0; k < NV; k++) begin
         base = rx_cnt;
         src_id = VEC[k][35:32];
         write_pid(VEC[k][31:0]);
         pid_value = ~VEC[k][31:0];
         wait_rx(base + 1, "R6 vector message arrives");
         chk(rx_msg[base] == exp_msg(VEC[k][31:0], VEC[k][35:32]), "R2 R5 R6 vector payload",
             rx_msg[base], exp_msg(VEC[k][31:0], VEC[k][35:32]));
         chk(rx_msg[base][5:0] == 6'b000010, "R4 type code", 64'(rx_msg[base][5:0]), 64'd2);
         chk(rx_len[base] == NB && rx_msg[base][43:42] == 2'b00, "R3 length and pad",
             64'(rx_len[base]), 64'(NB));
         idle_cycles(3);
      end

      // R8: writes during transmission; only newest survives, gapless
      base = rx_cnt;
      src_id = 4'h2;
      write_pid(32'hAAAA_0001);
      idle_cycles(2);
      write_pid(32'hBBBB_0002);
      idle_cycles(1);
      write_pid(32'hCCCC_0003);
      wait_rx(base + 2, "R8 queued message arrives");
      idle_cycles(30); #1;
      chk(rx_cnt == base + 2, "R8 overwritten write dropped", 64'(rx_cnt), 64'(base + 2));
      chk(rx_msg[base] == exp_msg(32'hAAAA_0001, 4'h2), "R8 first message", rx_msg[base],
          exp_msg(32'hAAAA_0001, 4'h2));
      chk(rx_msg[base+1] == exp_msg(32'hCCCC_0003, 4'h2), "R8 newest pending sent",
          rx_msg[base+1], exp_msg(32'hCCCC_0003, 4'h2));
      chk(rx_start[base+1] == rx_end[base] + 1, "R8 no gap after last beat",
          64'(rx_start[base+1]), 64'(rx_end[base] + 1));

      // R8: write in the very cycle the first is loaded
      base = rx_cnt;
      @(negedge clk);
      pid_value = 32'h0D0D_0D0D; pid_wr = 1'b1;
      @(negedge clk);
      pid_value = 32'h0E0E_0E0E;
      @(negedge clk);
      pid_wr = 1'b0;
      wait_rx(base + 2, "R8 back-to-back arrives");
      chk(rx_msg[base] == exp_msg(32'h0D0D_0D0D, 4'h2), "R8 back-to-back first",
          rx_msg[base], exp_msg(32'h0D0D_0D0D, 4'h2));
      chk(rx_msg[base+1] == exp_msg(32'h0E0E_0E0E, 4'h2), "R8 back-to-back second",
          rx_msg[base+1], exp_msg(32'h0E0E_0E0E, 4'h2));
      idle_cycles(20); #1;

      chk(frame_err == 0, "R7 framing sequence", 64'(frame_err), 64'd0);
      chk(idle_err == 0, "R3 idle data zero", 64'(idle_err), 64'd0);
      chk(frame == 2'b11, "R7 idle at end", 64'(frame), 64'd3);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule